// File: doc/BRIEF.md
# Power-Fail and Power-Up Supervisor

This block sits between the digitized supply comparators of a battery-free non-volatile memory and the rest of its control logic. It filters the "supply above switch threshold" comparator output. It then sequences what has to happen automatically when power goes away and when it comes back.

On a confirmed loss of supply, the block decides whether an automatic save is worth doing. A save is worth doing only when the array has been written since the last save completed, the backup capacitor is in use and the capacitor is above its own threshold. If so, the block pulls the shared busy line low for a short window and reads the line back. If the line really went low, the block hands one request to the save engine. If some external driver is holding the line high, the block lets go and abandons the save. This gives the board a way to disable the power-fail save on the fly.

While the supply is low, a restore is kept pending. The restore starts automatically once the filtered supply is back above threshold and runs for a fixed number of cycles. A new dip cancels a running restore and leaves it pending. User access stays blocked from reset until the first restore has finished, and it is also blocked whenever the supply is low or a restore is running.

Top module: `pwr_supervisor`

## Requirements
- R1: In the cycle after a synchronous reset, the outputs read as follows: `sup_ok`=0, `busy_pull`=0, `auto_save_req`=0, `restore_active`=0, `restore_pending`=1, `access_ok`=0.
- R2: `sup_ok` takes the value of `sup_raw` only after `sup_raw` has differed from `sup_ok` on DEB_CYCLES consecutive clock edges. A shorter excursion leaves `sup_ok` unchanged.
- R3: A falling `sup_ok` raises `busy_pull` on the following clock edge when three conditions hold: the dirty flag is set, `cap_tied`=0 and `vcap_ok`=1.
- R4: If `busy_in` is sampled low (0) on an edge while `busy_pull` is high, `busy_pull` drops on that edge and `auto_save_req` is high for exactly that one following cycle.
- R5: If `busy_in` stays high (1) on every edge of the pull window, `busy_pull` drops after PULL_CYCLES cycles and no `auto_save_req` is issued.
- R6: A `write_seen` pulse sets the dirty flag and a `save_done` pulse clears it. When both arrive in the same cycle, the flag stays set. With the flag clear, a supply fall produces neither a pull nor a request.
- R7: With `cap_tied`=1, or with `vcap_ok`=0, at the time of the fall, a supply fall produces neither a pull nor a request.
- R8: `restore_pending` is 1 in every cycle that follows a cycle with `sup_ok`=0.
- R9: A rising `sup_ok` with a restore pending raises `restore_active` on the next edge. `restore_active` then stays high for exactly RESTORE_CYCLES cycles, after which `restore_pending` clears.
- R10: If `sup_ok` falls while `restore_active` is high, `restore_active` drops on the next edge and the restore stays pending. The next rise runs a full-length restore.
- R11: `access_ok` is 0 from reset until the first restore completes. After that, `access_ok` equals `sup_ok` AND NOT `restore_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sup_raw | input | 1 | Digitized comparator: supply above switch threshold |
| vcap_ok | input | 1 | Digitized comparator: backup capacitor above threshold |
| cap_tied | input | 1 | 1 = capacitor tied to supply, power-fail save disabled |
| busy_in | input | 1 | Read-back of the shared busy line (0 = low) |
| write_seen | input | 1 | One-cycle pulse per user write to the array |
| save_done | input | 1 | One-cycle pulse when any save has completed |
| sup_ok | output | 1 | Filtered supply-good level |
| busy_pull | output | 1 | Drive the shared busy line low |
| auto_save_req | output | 1 | One-cycle request to the save engine |
| restore_active | output | 1 | Automatic restore in progress |
| restore_pending | output | 1 | Restore latched, waiting for supply |
| access_ok | output | 1 | User reads and writes allowed |

## Verification
The bench drives several kinds of stimulus: supply glitches one cycle shorter than the filter, falls with and without a prior write, falls with the busy line held high from outside, and falls with the capacitor tied off or below its threshold. A filter that counted non-consecutive edges would let the glitch through. A design that ignored the read-back would issue a save against a held line. It also covers a write and a save completion in the same cycle, where the wrong priority would silently skip the next power-fail save. A second dip during a restore is covered too: a design that resumed the restore instead of restarting it, or that cleared the pending flag, would grant access after a short restore.

// File: rtl/pwrsup_pkg.sv
package pwrsup_pkg;

    typedef enum logic [1:0] {
        PF_IDLE = 2'd0,
        PF_PULL = 2'd1,
        PF_REQ  = 2'd2
    } pf_state_e;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } sup_evt_t;

    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/sup_debounce.sv
module sup_debounce
    import pwrsup_pkg::*;
#(
    parameter int DEB_CYCLES = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     raw,
    output sup_evt_t evt
);
    localparam int CW = cnt_width(DEB_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            evt     <= '0;
            run_cnt <= '0;
        end else begin
            evt.rise <= 1'b0;
            evt.fall <= 1'b0;
            if (raw == evt.level) begin
                run_cnt <= '0;
            end else if (run_cnt == LAST) begin
                evt.level <= raw;
                evt.rise  <= raw;
                evt.fall  <= ~raw;
                run_cnt   <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pf_save_ctl.sv
module pf_save_ctl
    import pwrsup_pkg::*;
#(
    parameter int PULL_CYCLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic fall,
    input  logic cap_tied,
    input  logic vcap_ok,
    input  logic busy_in,
    input  logic write_seen,
    input  logic save_done,
    output logic busy_pull,
    output logic save_req
);
    localparam int CW = cnt_width(PULL_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(PULL_CYCLES - 1);

    pf_state_e     state;
    logic [CW-1:0] win_cnt;
    logic          dirty;
    logic          arm;

    // a write in the same cycle as a completion wins
    always_ff @(posedge clk) begin
        if (rst)             dirty <= 1'b0;
        else if (write_seen) dirty <= 1'b1;
        else if (save_done)  dirty <= 1'b0;
    end

    assign arm = fall & dirty & ~cap_tied & vcap_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= PF_IDLE;
            win_cnt <= '0;
        end else begin
            unique case (state)
                PF_IDLE: begin
                    win_cnt <= '0;
                    if (arm) state <= PF_PULL;
                end
                PF_PULL: begin
                    if (!busy_in) begin
                        state <= PF_REQ;
                    end else if (win_cnt == LAST) begin
                        state <= PF_IDLE;
                    end else begin
                        win_cnt <= win_cnt + 1'b1;
                    end
                end
                PF_REQ:  state <= PF_IDLE;
                default: state <= PF_IDLE;
            endcase
        end
    end

    assign busy_pull = (state == PF_PULL);
    assign save_req  = (state == PF_REQ);
endmodule

// File: rtl/restore_ctl.sv
module restore_ctl
    import pwrsup_pkg::*;
#(
    parameter int RESTORE_CYCLES = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic level,
    input  logic rise,
    output logic active,
    output logic pending,
    output logic boot_done
);
    localparam int CW = cnt_width(RESTORE_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(RESTORE_CYCLES - 1);

    logic [CW-1:0] dur_cnt;
    logic          finish;

    assign finish = active & level & (dur_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            pending   <= 1'b1;
            boot_done <= 1'b0;
            dur_cnt   <= '0;
        end else begin
            if (active) begin
                if (!level) begin
                    active <= 1'b0;
                end else if (finish) begin
                    active    <= 1'b0;
                    boot_done <= 1'b1;
                end else begin
                    dur_cnt <= dur_cnt + 1'b1;
                end
            end else if (rise && pending) begin
                active  <= 1'b1;
                dur_cnt <= '0;
            end

            if (!level)      pending <= 1'b1;
            else if (finish) pending <= 1'b0;
        end
    end
endmodule

// File: rtl/pwr_supervisor.sv
module pwr_supervisor
    import pwrsup_pkg::*;
#(
    parameter int DEB_CYCLES     = 4,
    parameter int PULL_CYCLES    = 3,
    parameter int RESTORE_CYCLES = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic sup_raw,
    input  logic vcap_ok,
    input  logic cap_tied,
    input  logic busy_in,
    input  logic write_seen,
    input  logic save_done,
    output logic sup_ok,
    output logic busy_pull,
    output logic auto_save_req,
    output logic restore_active,
    output logic restore_pending,
    output logic access_ok
);
    sup_evt_t evt;
    logic     boot_done;

    sup_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
        .clk (clk),
        .rst (rst),
        .raw (sup_raw),
        .evt (evt)
    );

    pf_save_ctl #(.PULL_CYCLES(PULL_CYCLES)) u_pf (
        .clk        (clk),
        .rst        (rst),
        .fall       (evt.fall),
        .cap_tied   (cap_tied),
        .vcap_ok    (vcap_ok),
        .busy_in    (busy_in),
        .write_seen (write_seen),
        .save_done  (save_done),
        .busy_pull  (busy_pull),
        .save_req   (auto_save_req)
    );

    restore_ctl #(.RESTORE_CYCLES(RESTORE_CYCLES)) u_rst (
        .clk       (clk),
        .rst       (rst),
        .level     (evt.level),
        .rise      (evt.rise),
        .active    (restore_active),
        .pending   (restore_pending),
        .boot_done (boot_done)
    );

    assign sup_ok    = evt.level;
    assign access_ok = boot_done & evt.level & ~restore_active;
endmodule

// File: rtl/pwr_supervisor_chk.sv
module pwr_supervisor_chk #(
    parameter int PULL_CYCLES = 3
) (
    input logic clk,
    input logic rst,
    input logic sup_raw,
    input logic vcap_ok,
    input logic cap_tied,
    input logic busy_in,
    input logic sup_ok,
    input logic busy_pull,
    input logic auto_save_req,
    input logic restore_active,
    input logic restore_pending,
    input logic access_ok
);
    int pull_len;

    always_ff @(posedge clk) begin
        if (rst)            pull_len <= 0;
        else if (busy_pull) pull_len <= pull_len + 1;
        else                pull_len <= 0;
    end

    p_filter_follows_r2: assert property (@(posedge clk) disable iff (rst)
        (sup_ok != $past(sup_ok)) |-> ($past(sup_raw) == sup_ok));

    p_pull_gated_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_pull) |-> ($past(!cap_tied) && $past(vcap_ok)));

    p_req_after_low_r4: assert property (@(posedge clk) disable iff (rst)
        auto_save_req |-> ($past(busy_pull) && !$past(busy_in)));

    p_req_single_r4: assert property (@(posedge clk) disable iff (rst)
        auto_save_req |=> !auto_save_req);

    p_pull_window_r5: assert property (@(posedge clk) disable iff (rst)
        pull_len <= PULL_CYCLES);

    p_pending_low_r8: assert property (@(posedge clk) disable iff (rst)
        !sup_ok |=> restore_pending);

    p_cancel_r10: assert property (@(posedge clk) disable iff (rst)
        (restore_active && !sup_ok) |=> !restore_active);

    p_access_r11: assert property (@(posedge clk) disable iff (rst)
        access_ok |-> (sup_ok && !restore_active));
endmodule

bind pwr_supervisor pwr_supervisor_chk #(.PULL_CYCLES(PULL_CYCLES)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .sup_raw         (sup_raw),
    .vcap_ok         (vcap_ok),
    .cap_tied        (cap_tied),
    .busy_in         (busy_in),
    .sup_ok          (sup_ok),
    .busy_pull       (busy_pull),
    .auto_save_req   (auto_save_req),
    .restore_active  (restore_active),
    .restore_pending (restore_pending),
    .access_ok       (access_ok)
);

// File: tb/test_pwr_supervisor.sv
module test_pwr_supervisor;
    localparam int CLK_PERIOD = 10;
    localparam int DEB  = 4;
    localparam int PULL = 3;
    localparam int RC   = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sup_raw = 1'b0, vcap_ok = 1'b1, cap_tied = 1'b0;
    logic ext_hold = 1'b0, write_seen = 1'b0, save_done = 1'b0;
    logic busy_in;
    logic sup_ok, busy_pull, auto_save_req, restore_active, restore_pending, access_ok;

    always #(CLK_PERIOD/2) clk = ~clk;

    // shared line: high by pull-up or an external driver, low when pulled
    assign busy_in = ext_hold ? 1'b1 : ~busy_pull;

    pwr_supervisor #(.DEB_CYCLES(DEB), .PULL_CYCLES(PULL), .RESTORE_CYCLES(RC)) i_pwr_supervisor (
        .clk(clk), .rst(rst), .sup_raw(sup_raw), .vcap_ok(vcap_ok), .cap_tied(cap_tied),
        .busy_in(busy_in), .write_seen(write_seen), .save_done(save_done),
        .sup_ok(sup_ok), .busy_pull(busy_pull), .auto_save_req(auto_save_req),
        .restore_active(restore_active), .restore_pending(restore_pending), .access_ok(access_ok)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int  m_filt = 0, m_run = 0, m_fell = 0, m_rose = 0, m_dirty = 0;
    int  m_mode = 0, m_win = 0;
    int  m_act = 0, m_dur = 0, m_pend = 1, m_boot = 0;
    bit  started = 0;

    always @(posedge clk) begin
        int f, r, fl, rs, d, md, w, a, du, p, b;
        started <= 1'b1;
        if (rst) begin
            m_filt = 0; m_run = 0; m_fell = 0; m_rose = 0; m_dirty = 0;
            m_mode = 0; m_win = 0; m_act = 0; m_dur = 0; m_pend = 1; m_boot = 0;
        end else begin
            f = m_filt; r = m_run; fl = 0; rs = 0;
            if (int'(sup_raw) == m_filt) r = 0;
            else if (m_run == DEB - 1) begin f = int'(sup_raw); r = 0; rs = f; fl = 1 - f; end
            else r = m_run + 1;
            d = write_seen ? 1 : (save_done ? 0 : m_dirty);
            md = m_mode; w = m_win;
            if (m_mode == 0) begin
                w = 0;
                if (m_fell == 1 && m_dirty == 1 && !cap_tied && vcap_ok) md = 1;
            end else if (m_mode == 1) begin
                if (!busy_in) md = 2;
                else if (m_win == PULL - 1) md = 0;
                else w = m_win + 1;
            end else md = 0;
            a = m_act; du = m_dur; p = m_pend; b = m_boot;
            if (m_act == 1) begin
                if (m_filt == 0) a = 0;
                else if (m_dur == RC - 1) begin a = 0; b = 1; p = 0; end
                else du = m_dur + 1;
            end else if (m_rose == 1 && m_pend == 1) begin a = 1; du = 0; end
            if (m_filt == 0) p = 1;
            m_filt = f; m_run = r; m_fell = fl; m_rose = rs; m_dirty = d;
            m_mode = md; m_win = w; m_act = a; m_dur = du; m_pend = p; m_boot = b;
        end
    end

    // per-cycle comparison plus event counters
    int n_pull = 0, n_req = 0, n_ra = 0, cur_len = 0, max_len = 0;
    logic prev_pull = 1'b0;
    always @(negedge clk) begin
        if (started && !finished) begin
            check("R2 sup_ok",          int'(sup_ok),          m_filt);
            check("R3 busy_pull",       int'(busy_pull),       int'(m_mode == 1));
            check("R4 auto_save_req",   int'(auto_save_req),   int'(m_mode == 2));
            check("R9 restore_active",  int'(restore_active),  m_act);
            check("R8 restore_pending", int'(restore_pending), m_pend);
            check("R11 access_ok",      int'(access_ok),       int'(m_boot == 1 && m_filt == 1 && m_act == 0));
        end
        if (busy_pull && !prev_pull) n_pull++;
        if (auto_save_req) n_req++;
        if (restore_active) n_ra++;
        cur_len = busy_pull ? cur_len + 1 : 0;
        if (cur_len > max_len) max_len = cur_len;
        prev_pull = busy_pull;
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic do_write();
        write_seen = 1'b1; cyc(1); write_seen = 1'b0;
    endtask
    task automatic power_up();
        sup_raw = 1'b1; cyc(DEB + RC + 6);
    endtask
    task automatic power_down();
        sup_raw = 1'b0; cyc(DEB + PULL + 6);
    endtask

    initial begin
        int p0, q0;
        cyc(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 sup_ok", int'(sup_ok), 0);
        check("R1 busy_pull", int'(busy_pull), 0);
        check("R1 auto_save_req", int'(auto_save_req), 0);
        check("R1 restore_active", int'(restore_active), 0);
        check("R1 restore_pending", int'(restore_pending), 1);
        check("R1 access_ok", int'(access_ok), 0);

        // R2 glitch one cycle short of the filter
        sup_raw = 1'b1; cyc(DEB - 1); sup_raw = 1'b0; cyc(6);
        check("R2 glitch ignored", int'(sup_ok), 0);
        check("R11 no access before first restore", int'(access_ok), 0);

        // R9 first restore
        n_ra = 0;
        power_up();
        check("R9 restore length", n_ra, RC);
        check("R9 pending cleared", int'(restore_pending), 0);
        check("R11 access after restore", int'(access_ok), 1);

        // R6 fall without write
        p0 = n_pull; q0 = n_req;
        power_down();
        check("R8 pending while low", int'(restore_pending), 1);
        check("R6 no pull when clean", n_pull - p0, 0);
        power_up();

        // R3/R4 normal power-fail save
        do_write();
        p0 = n_pull; q0 = n_req;
        power_down();
        check("R3 pull issued", n_pull - p0, 1);
        check("R4 request issued", n_req - q0, 1);
        power_up();

        // R5 line held high externally
        do_write();
        ext_hold = 1'b1; max_len = 0;
        p0 = n_pull; q0 = n_req;
        power_down();
        check("R5 pull attempted", n_pull - p0, 1);
        check("R5 no request", n_req - q0, 0);
        check("R5 window length", max_len, PULL);
        ext_hold = 1'b0;
        power_up();

        // R7 capacitor tied off, then capacitor low
        do_write();
        cap_tied = 1'b1; p0 = n_pull; q0 = n_req;
        power_down();
        check("R7 tied no pull", n_pull - p0, 0);
        cap_tied = 1'b0;
        power_up();
        vcap_ok = 1'b0; p0 = n_pull;
        power_down();
        check("R7 vcap low no pull", n_pull - p0, 0);
        check("R7 no request", n_req - q0, 0);
        vcap_ok = 1'b1;
        power_up();

        // R6 write and completion in the same cycle keep the flag set
        write_seen = 1'b1; save_done = 1'b1; cyc(1);
        write_seen = 1'b0; save_done = 1'b0;
        p0 = n_pull;
        power_down();
        check("R6 write wins", n_pull - p0, 1);
        power_up();
        do_write();
        save_done = 1'b1; cyc(1); save_done = 1'b0;
        p0 = n_pull;
        power_down();
        check("R6 cleared by save_done", n_pull - p0, 0);

        // R10 dip during restore
        sup_raw = 1'b1; cyc(DEB + 5);
        check("R10 restore running", int'(restore_active), 1);
        sup_raw = 1'b0; cyc(DEB + 2);
        check("R10 restore cancelled", int'(restore_active), 0);
        check("R10 still pending", int'(restore_pending), 1);
        check("R11 no access when low", int'(access_ok), 0);
        n_ra = 0;
        power_up();
        check("R10 full restore after dip", n_ra, RC);
        check("R11 access restored", int'(access_ok), 1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        cyc(20000);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule